// File: doc/BRIEF.md
# Load/Store Address and Data Unit

This unit carries out a single-register memory transfer for a pipelined core. It handles word, unsigned byte, unsigned halfword, signed byte and signed halfword transfers. It takes the decoded transfer word, the base register value, an offset that an upstream shifter has already evaluated, and the value to be stored. From these it forms the effective address and drives a request/ready memory port that carries an access size. When the access completes, it returns the loaded value and the updated base value on a result port, each with its own write enable.

Two transfer forms are supported. The word/byte form takes its offset from the offset input. The halfword/signed form takes either an 8-bit immediate held inside the transfer word or the offset input. Register 15 is handled as a program counter that runs ahead of the executing transfer. When register 15 is used as the base, it is pulled back by 8. When register 15 is the stored register, the access address is pushed forward by 4. A small state machine sequences idle, request and write-back. It rejects malformed halfword-form encodings without touching memory.

Top module: `ldst_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `err`, `mem_req`, `res_rd_we` and `res_base_we` are all 0.
- R2: Transfer word bits decode as follows: bit 20 = load (1) or store (0), bit 21 = write-back, bit 23 = add (1) or subtract (0) offset, bit 24 = pre-index (1) or post-index (0). `mem_we` is the inverse of bit 20.
- R3: Let M be the base value plus or minus the offset. With pre-index the access address is M. With post-index the access address is the unmodified base.
- R4: The base register write enable pulses when post-index is selected or bit 21 is set. The value returned is M, and the index returned is bits [19:16].
- R5: In the halfword form, bit 22 = 1 selects the immediate offset {bits[11:8], bits[3:0]}. Bit 22 = 0 selects the offset input. In the word form the offset input is always used.
- R6: Load results are extended as follows. Word: the full word. Word-form byte (bit 22 = 1): the low 8 bits, zero-extended. Halfword form with bit 6 = 0 and bit 5 = 1: the low 16 bits, zero-extended. Bit 6 = 1 and bit 5 = 1: sign-extended from bit 15. Bit 6 = 1 and bit 5 = 0: sign-extended from bit 7. The destination enable pulses only for loads, and the returned index is bits [15:12].
- R7: When the base index (bits [19:16]) is 15, the base value is reduced by 8 before any address arithmetic, including the write-back value.
- R8: A store whose source index (bits [15:12]) is 15 uses an access address 4 higher than R3 gives. The write-back value is not changed by this.
- R9: Store data is the low 8 bits zero-extended for byte accesses, the low 16 bits zero-extended for halfword accesses, and the full value for word accesses.
- R10: `mem_size` is 00 for byte, 01 for halfword and 10 for word. Word form: bit 22 = 1 gives byte, otherwise word. Halfword form: bit 5 = 1 gives halfword, otherwise byte.
- R11: `mem_req` rises one cycle after an accepted request and holds, with a stable address, until `mem_ready`. The result enables then pulse for exactly one cycle, after which the unit is idle again. A request presented while `busy` is ignored.
- R12: A halfword-form request is rejected if any of these holds: a store with bit 6 set, post-index with bit 21 set, bits 5 and 6 both 0, or bit 7 or bit 4 clear. A rejected request pulses `err` for one cycle, raises no memory request and produces no result enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Transfer request, taken when idle |
| op_hw_form | input | 1 | 1 = halfword/signed form, 0 = word/byte form |
| op_insn | input | 25 | Transfer word bits [24:0] |
| op_base | input | 32 | Base register value |
| op_offset | input | 32 | Evaluated offset value |
| op_store_val | input | 32 | Source register value for stores |
| busy | output | 1 | A transfer is in progress |
| err | output | 1 | One-cycle pulse on a rejected encoding |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 32 | Access address |
| mem_size | output | 2 | Access size |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory completes the access |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| res_rd_we | output | 1 | Destination register write enable |
| res_rd_idx | output | 4 | Destination register index |
| res_rd_data | output | 32 | Extended load value |
| res_base_we | output | 1 | Base register write enable |
| res_base_idx | output | 4 | Base register index |
| res_base_data | output | 32 | Updated base value |

## Verification
The hardest case to reach is register 15 acting as both the base and the stored register in a post-indexed store. There, the access address carries the +4 correction while the write-back value must not. That case only shows up when the base and source indices, the index mode and the direction all line up. The stimulus sweeps every combination of the index, direction, write-back, load and size bits with both indices drawn from {ordinary register, 15}. It also varies the memory latency, so the held request and the stable address are seen across zero-wait and multi-wait accesses.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int unsigned BIT_LOAD  = 20;
  localparam int unsigned BIT_WBACK = 21;
  localparam int unsigned BIT_SEL22 = 22;
  localparam int unsigned BIT_UP    = 23;
  localparam int unsigned BIT_PRE   = 24;
  localparam int unsigned BIT_HALF  = 5;
  localparam int unsigned BIT_SGN   = 6;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_WB   = 2'b10
  } ldst_state_e;

  typedef struct packed {
    logic load;
    logic wback;
    logic up;
    logic pre;
    logic sel22;
    logic half;
    logic sgn;
    logic hw_form;
  } ldst_ctl_t;
endpackage

// File: rtl/ldst_addr.sv
module ldst_addr
  import ldst_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned IW       = 4,
  parameter int unsigned BASE_ADJ = 8,
  parameter int unsigned SRC_ADJ  = 4
) (
  input  ldst_ctl_t         ctl,
  input  logic [IW-1:0]     rn,
  input  logic [IW-1:0]     rd,
  input  logic [7:0]        imm8,
  input  logic [DW-1:0]     base,
  input  logic [DW-1:0]     offset,
  output logic [DW-1:0]     acc_addr,
  output logic [DW-1:0]     wb_addr,
  output logic [1:0]        size
);
  localparam logic [IW-1:0] PC_IDX = {IW{1'b1}};
  localparam logic [DW-1:0] BADJ   = DW'(BASE_ADJ);
  localparam logic [DW-1:0] SADJ   = DW'(SRC_ADJ);

  logic [DW-1:0] base_adj;
  logic [DW-1:0] off_sel;
  logic [DW-1:0] moved;
  logic [DW-1:0] acc_raw;

  always_comb begin
    base_adj = (rn == PC_IDX) ? (base - BADJ) : base;
    off_sel  = (ctl.hw_form && ctl.sel22) ? DW'(imm8) : offset;
    moved    = ctl.up ? (base_adj + off_sel) : (base_adj - off_sel);
    acc_raw  = ctl.pre ? moved : base_adj;
    acc_addr = (!ctl.load && (rd == PC_IDX)) ? (acc_raw + SADJ) : acc_raw;
    wb_addr  = moved;
    if (ctl.hw_form) size = ctl.half ? SZ_HALF : SZ_BYTE;
    else             size = ctl.sel22 ? SZ_BYTE : SZ_WORD;
  end
endmodule

// File: rtl/ldst_lane.sv
module ldst_lane
  import ldst_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  ldst_ctl_t     ctl,
  input  logic [1:0]    size,
  input  logic [DW-1:0] store_val,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] ldata
);
  always_comb begin
    unique case (size)
      SZ_BYTE: wdata = {{(DW-8){1'b0}}, store_val[7:0]};
      SZ_HALF: wdata = {{(DW-16){1'b0}}, store_val[15:0]};
      default: wdata = store_val;
    endcase
    if (!ctl.hw_form) begin
      ldata = ctl.sel22 ? {{(DW-8){1'b0}}, rdata[7:0]} : rdata;
    end else if (ctl.sgn) begin
      ldata = ctl.half ? {{(DW-16){rdata[15]}}, rdata[15:0]}
                       : {{(DW-8){rdata[7]}}, rdata[7:0]};
    end else begin
      ldata = {{(DW-16){1'b0}}, rdata[15:0]};
    end
  end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_hw_form,
  input  logic [24:0]   op_insn,
  input  logic [DW-1:0] op_base,
  input  logic [DW-1:0] op_offset,
  input  logic [DW-1:0] op_store_val,
  output logic          busy,
  output logic          err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          res_rd_we,
  output logic [IW-1:0] res_rd_idx,
  output logic [DW-1:0] res_rd_data,
  output logic          res_base_we,
  output logic [IW-1:0] res_base_idx,
  output logic [DW-1:0] res_base_data
);
  ldst_state_e   state_q, state_d;
  ldst_ctl_t     ctl_in, ctl_q;
  logic [IW-1:0] rn_in, rd_in, rn_q, rd_q;
  logic [DW-1:0] acc_in, wba_in, wdat_in;
  logic [DW-1:0] acc_q, wba_q, wdat_q, rdata_q, ldata;
  logic [1:0]    size_in, size_q;
  logic          bad_in, accept, accept_ok, err_d, err_q;

  always_comb begin
    ctl_in.load    = op_insn[BIT_LOAD];
    ctl_in.wback   = op_insn[BIT_WBACK];
    ctl_in.up      = op_insn[BIT_UP];
    ctl_in.pre     = op_insn[BIT_PRE];
    ctl_in.sel22   = op_insn[BIT_SEL22];
    ctl_in.half    = op_insn[BIT_HALF];
    ctl_in.sgn     = op_insn[BIT_SGN];
    ctl_in.hw_form = op_hw_form;
    rn_in = op_insn[16 +: IW];
    rd_in = op_insn[12 +: IW];
    bad_in = op_hw_form &&
             ((!ctl_in.load && ctl_in.sgn) ||
              (!ctl_in.pre && ctl_in.wback) ||
              (!ctl_in.half && !ctl_in.sgn) ||
              !op_insn[7] || !op_insn[4]);
  end

  ldst_addr #(.DW(DW), .IW(IW)) u_addr (
    .ctl      (ctl_in),
    .rn       (rn_in),
    .rd       (rd_in),
    .imm8     ({op_insn[11:8], op_insn[3:0]}),
    .base     (op_base),
    .offset   (op_offset),
    .acc_addr (acc_in),
    .wb_addr  (wba_in),
    .size     (size_in)
  );

  ldst_lane #(.DW(DW)) u_lane_st (
    .ctl       (ctl_in),
    .size      (size_in),
    .store_val (op_store_val),
    .rdata     (rdata_q),
    .wdata     (wdat_in),
    .ldata     ()
  );

  ldst_lane #(.DW(DW)) u_lane_ld (
    .ctl       (ctl_q),
    .size      (size_q),
    .store_val (wdat_q),
    .rdata     (rdata_q),
    .wdata     (),
    .ldata     (ldata)
  );

  // next-state
  always_comb begin
    accept    = op_valid && (state_q == ST_IDLE);
    accept_ok = accept && !bad_in;
    err_d     = accept && bad_in;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_ok) state_d = ST_REQ;
      ST_REQ:  if (mem_ready) state_d = ST_WB;
      ST_WB:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      ctl_q   <= '0;
      rn_q    <= '0;
      rd_q    <= '0;
      acc_q   <= '0;
      wba_q   <= '0;
      wdat_q  <= '0;
      size_q  <= SZ_WORD;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (accept_ok) begin
        ctl_q  <= ctl_in;
        rn_q   <= rn_in;
        rd_q   <= rd_in;
        acc_q  <= acc_in;
        wba_q  <= wba_in;
        wdat_q <= wdat_in;
        size_q <= size_in;
      end
      if ((state_q == ST_REQ) && mem_ready) rdata_q <= mem_rdata;
    end
  end

  always_comb begin
    busy          = (state_q != ST_IDLE);
    err           = err_q;
    mem_req       = (state_q == ST_REQ);
    mem_we        = !ctl_q.load;
    mem_addr      = acc_q;
    mem_size      = size_q;
    mem_wdata     = wdat_q;
    res_rd_we     = (state_q == ST_WB) && ctl_q.load;
    res_rd_idx    = rd_q;
    res_rd_data   = ldata;
    res_base_we   = (state_q == ST_WB) && (!ctl_q.pre || ctl_q.wback);
    res_base_idx  = rn_q;
    res_base_data = wba_q;
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
  // R11
  wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd_we || res_base_we) |=> (!res_rd_we && !res_base_we && !busy));
  // R12
  err_noacc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mem_req && !res_rd_we && !res_base_we));
  // R10
  size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_size != 2'b11));
  // R6
  rd_we_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_rd_we |-> !mem_we);
  // R11
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(op_valid));
endmodule

// File: tb/ldst_unit_test.sv
`timescale 1ns/1ps
module ldst_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_hw_form;
  logic [24:0] op_insn;
  logic [31:0] op_base, op_offset, op_store_val;
  logic        busy, err, mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        res_rd_we, res_base_we;
  logic [3:0]  res_rd_idx, res_base_idx;
  logic [31:0] res_rd_data, res_base_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ldst_unit uut (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic run_op(input logic hw, input logic [24:0] insn,
                        input logic [31:0] base, input logic [31:0] offv,
                        input logic [31:0] sval, input logic [31:0] rdat,
                        input int lat);
    logic ld, wbk, up, pre, b22, h, s;
    logic [3:0] rn, rd;
    logic [31:0] off, badj, moved, acc, wd, rx;
    logic [1:0] sz;
    ld = insn[20]; wbk = insn[21]; b22 = insn[22]; up = insn[23]; pre = insn[24];
    h = insn[5]; s = insn[6]; rn = insn[19:16]; rd = insn[15:12];
    off   = (hw && b22) ? {24'd0, insn[11:8], insn[3:0]} : offv;
    badj  = (rn == 4'd15) ? base - 32'd8 : base;
    moved = up ? badj + off : badj - off;
    acc   = pre ? moved : badj;
    if (!ld && rd == 4'd15) acc = acc + 32'd4;
    sz = hw ? (h ? 2'b01 : 2'b00) : (b22 ? 2'b00 : 2'b10);
    wd = (sz == 2'b00) ? {24'd0, sval[7:0]} : (sz == 2'b01) ? {16'd0, sval[15:0]} : sval;
    if (!hw) rx = b22 ? {24'd0, rdat[7:0]} : rdat;
    else if (s) rx = h ? {{16{rdat[15]}}, rdat[15:0]} : {{24{rdat[7]}}, rdat[7:0]};
    else rx = {16'd0, rdat[15:0]};

    @(negedge clk);
    op_valid = 1'b1; op_hw_form = hw; op_insn = insn;
    op_base = base; op_offset = offv; op_store_val = sval;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R11", "req", {31'd0, mem_req}, 32'd1);
    chk("R3", "addr", mem_addr, acc);
    chk("R10", "size", {30'd0, mem_size}, {30'd0, sz});
    chk("R2", "we", {31'd0, mem_we}, {31'd0, !ld});
    if (!ld) chk("R9", "wdata", mem_wdata, wd);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk("R11", "held", {mem_req, busy, 30'd0} ^ {1'b0, 1'b0, mem_addr[29:0] ^ acc[29:0]},
          {1'b1, 1'b1, 30'd0});
    end
    mem_ready = 1'b1; mem_rdata = rdat;
    @(negedge clk);
    mem_ready = 1'b0; mem_rdata = 32'hDEAD_BEEF;
    chk("R6", "rd_we", {31'd0, res_rd_we}, {31'd0, ld});
    if (ld) begin
      chk("R6", "rd_data", res_rd_data, rx);
      chk("R6", "rd_idx", {28'd0, res_rd_idx}, {28'd0, rd});
    end
    chk("R4", "base_we", {31'd0, res_base_we}, {31'd0, (!pre || wbk)});
    if (!pre || wbk) begin
      chk("R4", "base_data", res_base_data, moved);
      chk("R4", "base_idx", {28'd0, res_base_idx}, {28'd0, rn});
    end
    @(negedge clk);
    chk("R11", "pulse_end", {29'd0, res_rd_we, res_base_we, busy}, 32'd0);
  endtask

  task automatic run_bad(input logic [24:0] insn);
    @(negedge clk);
    op_valid = 1'b1; op_hw_form = 1'b1; op_insn = insn;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R12", "err", {30'd0, err, mem_req}, 32'd2);
    @(negedge clk);
    chk("R12", "quiet", {27'd0, err, mem_req, res_rd_we, res_base_we, busy}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int i;
    logic [24:0] ins;
    logic [3:0] rn, rd;
    rst_n = 1'b0; op_valid = 1'b0; op_hw_form = 1'b0; op_insn = '0;
    op_base = '0; op_offset = '0; op_store_val = '0;
    mem_ready = 1'b0; mem_rdata = '0;
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "idle", {27'd0, busy, err, mem_req, res_rd_we, res_base_we}, 32'd0);

    i = 0;
    // word/byte form sweep: R2 R3 R4 R7 R8 R9 R10 R6
    for (int m = 0; m < 128; m++) begin
      rn = m[5] ? 4'd15 : 4'd4;
      rd = m[6] ? 4'd15 : 4'd2;
      ins = {m[0], m[1], m[2], m[3], m[4], rn, rd, 12'h5A5};
      run_op(1'b0, ins, 32'h1000_0100 + 32'(m * 36), 32'h0000_0040 + 32'(m),
             32'hA5C3_F18E ^ 32'(m), m[0] ? 32'h8000_8081 ^ 32'(m << 4) : 32'h1234_5677,
             m % 3);
      i++;
    end
    // halfword/signed form sweep: R5 R6 R9 R10
    for (int m = 0; m < 512; m++) begin
      logic pre, up, wb, ld, imm, h, s;
      pre = m[0]; up = m[1]; wb = m[2]; ld = m[3]; imm = m[4]; h = m[5]; s = m[6];
      if ((!ld && s) || (!pre && wb) || (!h && !s)) continue;
      rn = m[7] ? 4'd15 : 4'd9;
      rd = m[8] ? 4'd15 : 4'd1;
      ins = {pre, up, imm, wb, ld, rn, rd, 4'(m + 3), 1'b1, s, h, 1'b1, 4'(m * 7)};
      run_op(1'b1, ins, 32'h2000_0800 - 32'(m * 12), 32'h0000_0123 + 32'(m),
             32'h7F80_80FF + 32'(m), (m % 4 < 2) ? 32'h0000_80F0 + 32'(m) : 32'h1111_7F70 + 32'(m),
             (m / 2) % 4);
    end
    // R7 and R8 together: post-index store with base 15 and source 15
    run_op(1'b0, {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd15, 4'd15, 12'd0},
           32'h0000_0100, 32'h10, 32'hCAFE_0001, 32'h0, 2);
    // R12 rejected encodings
    run_bad({1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 4'd5, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd2}); // store signed
    run_bad({1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd3, 4'd5, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2}); // post + wb
    run_bad({1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3, 4'd5, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2}); // no H/S
    run_bad({1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3, 4'd5, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2}); // bit7 clear
    // R11 request while busy is ignored
    @(negedge clk);
    op_valid = 1'b1; op_hw_form = 1'b0; op_base = 32'h300; op_offset = 32'h8;
    op_insn = {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 4'd3, 12'd0};
    @(negedge clk);
    op_insn = {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6, 4'd7, 12'd0}; op_base = 32'h9000;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R11", "busy_ignore", mem_addr, 32'h308);
    chk("R11", "busy_we", {31'd0, mem_we}, 32'd0);
    mem_ready = 1'b1; mem_rdata = 32'h55;
    @(negedge clk);
    mem_ready = 1'b0;
    chk("R11", "busy_rd", {28'd0, res_rd_idx}, 32'd3);
    @(negedge clk);
    @(negedge clk);
    chk("R11", "idle_after", {31'd0, busy}, 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule